// File: doc/BRIEF.md
# System Watchdog Countdown Timer

This block is a system watchdog reached through a small byte-addressed register bus. A down-counter runs from a programmable initial value. It decrements once per slow tick from an internal prescaler. Software keeps the system alive by writing, with any data, to the count register, which reloads the counter.

When the counter runs out, the block sets a timeout flag and starts a new countdown. If the counter runs out a second time while that flag is still set, the block raises a one-cycle system-reset pulse. A reboot-gate bit can suppress that pulse. A halt bit in a shared control word freezes the countdown. A parameter selects a 6-bit or a 10-bit counter; the two variants keep the initial value in different registers. A second parameter sets how many clock cycles make one tick. At the nominal 0.6 s tick, a timeout of S seconds corresponds to S*10/6 ticks.

Top module: `wdg_timer`

## Requirements
- R1: After reset the halt bit (offset 0x08 bit 11) is 1 and the reboot-gate bit (offset 0x0C bit 0) is 1. The initial-value field and the count are both 4. Every status flag is 0, and timeout_o and sys_rst_o are low.
- R2: A read of offset 0x00 returns the current count, zero-extended. That is 6 bits when WIDE=0 and 10 bits when WIDE=1.
- R3: The initial value is a field in the low bits of an init register. With WIDE=0 the register is 8 bits at offset 0x01 and the field is bits 5:0. With WIDE=1 the register is 16 bits at offset 0x12 and the field is bits 9:0. Bits above the field store what was written and read back. A write whose field value is 0 to 3 leaves the field unchanged. The init offset of the other variant reads 0.
- R4: Any write to offset 0x00, with any data, loads the count from the initial-value field on the next edge. This load wins over a tick in the same cycle and also works while halted.
- R5: The control word at offset 0x08 is 16 bits and reads back as written. While bit 11 is 1 the count does not change except by a reload write.
- R6: The prescaler runs freely from reset and issues one tick every TICK_CLKS cycles. The first tick comes TICK_CLKS cycles after reset is released. On each tick with the halt bit 0, a nonzero count drops by one.
- R7: A tick that finds the count at 0 is an expiry. An expiry reloads the count from the field and sets the timeout flag. The flag is bit 3 of offset 0x04 and is mirrored on timeout_o from the next cycle.
- R8: An expiry while the timeout flag is already set is a second expiry. It sets bit 1 of offset 0x06. If the reboot gate is 0 it also drives sys_rst_o high for exactly the following cycle and sets bit 0 of offset 0x06.
- R9: While the reboot-gate bit is 1, sys_rst_o stays low and bit 0 of offset 0x06 is not set. The bit is read/write.
- R10: The status registers at offsets 0x04 and 0x06 are write-1-to-clear. Writing 0 to a flag keeps it. A flag set by an event in the same cycle as a clear stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Byte offset of the register accessed |
| we_i | input | 1 | Write strobe for the current cycle |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| timeout_o | output | 1 | Timeout flag level |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
Directed sequences run the counter to expiry twice in a row. The first run has the reboot gate set and the second has it clear, which separates a suppressed escalation from an issued one. One reload write is placed exactly on a tick cycle to show that the load wins over the decrement. Init writes with field values below 4 and with nonzero upper bits distinguish a rejected field from stored upper bits. Random register traffic then mixes halts, reloads, gate changes and status clears. It runs against a narrow and a wide instance in lockstep with a cycle-level model, so the width masking of each variant and the offset that variant does not use are compared after every operation.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_CNT    = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_INIT_N = 5'h01;
  localparam logic [ADDR_W-1:0] OFS_STAT_A = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT_B = 5'h06;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_GATE   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_INIT_W = 5'h12;

  localparam int HALT_BIT   = 11;
  localparam int TO_BIT     = 3;
  localparam int INIT_FLOOR = 4;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int TICK_CLKS = 150_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int PW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CLKS - 1);

  logic [PW-1:0] pcnt_q;

  assign tick_o = (pcnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pcnt_q <= '0;
    else if (tick_o) pcnt_q <= '0;
    else             pcnt_q <= pcnt_q + 1'b1;
  end

  generate
    if (TICK_CLKS > 1) begin : g_spacing
      a_r6_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          halt_i,
  input  logic          reload_i,
  input  logic [CW-1:0] init_i,
  output logic [CW-1:0] cnt_o,
  output logic          expire_o
);
  import wdg_pkg::*;

  logic [CW-1:0] cnt_q;
  logic          step;

  assign step     = tick_i & ~halt_i & ~reload_i;
  assign expire_o = step & (cnt_q == '0);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= CW'(INIT_FLOOR);
    else if (reload_i) cnt_q <= init_i;
    else if (expire_o) cnt_q <= init_i;
    else if (step)     cnt_q <= cnt_q - 1'b1;
  end

  a_r4_reload_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> cnt_o == $past(init_i));
  a_r5_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !reload_i) |=> $stable(cnt_o));
  a_r6_dec_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !halt_i && !reload_i && cnt_o != '0) |=> cnt_o == $past(cnt_o) - 1'b1);
  a_r7_expire_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> cnt_o == $past(init_i));
endmodule

// File: rtl/wdg_status.sv
module wdg_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       expire_i,
  input  logic       gate_i,
  input  logic       clr_to_i,
  input  logic [1:0] clr_b_i,
  output logic       to_flag_o,
  output logic [1:0] stat_b_o,
  output logic       sys_rst_o
);
  logic       to_q;
  logic [1:0] stb_q;
  logic       rst_q;
  logic       second;
  logic       fire;

  assign second = expire_i & to_q;
  assign fire   = second & ~gate_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_q  <= 1'b0;
      stb_q <= '0;
      rst_q <= 1'b0;
    end else begin
      // event set wins over a same-cycle clear
      if (expire_i)      to_q <= 1'b1;
      else if (clr_to_i) to_q <= 1'b0;
      if (second)          stb_q[1] <= 1'b1;
      else if (clr_b_i[1]) stb_q[1] <= 1'b0;
      if (fire)            stb_q[0] <= 1'b1;
      else if (clr_b_i[0]) stb_q[0] <= 1'b0;
      rst_q <= fire;
    end
  end

  assign to_flag_o = to_q;
  assign stat_b_o  = stb_q;
  assign sys_rst_o = rst_q;

  a_r7_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> to_flag_o);
  a_r8_pulse_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> !sys_rst_o);
  a_r9_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_i |=> !sys_rst_o);
  a_r8_needs_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> stat_b_o[1]);
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs #(
  parameter bit WIDE = 1'b0,
  parameter int CW   = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [wdg_pkg::ADDR_W-1:0]   addr_i,
  input  logic                         we_i,
  input  logic [wdg_pkg::DATA_W-1:0]   wdata_i,
  input  logic [CW-1:0]                cnt_i,
  input  logic                         to_flag_i,
  input  logic [1:0]                   stat_b_i,
  output logic [wdg_pkg::DATA_W-1:0]   rdata_o,
  output logic [CW-1:0]                init_o,
  output logic                         halt_o,
  output logic                         gate_o,
  output logic                         reload_o,
  output logic                         clr_to_o,
  output logic [1:0]                   clr_b_o
);
  import wdg_pkg::*;

  localparam int IREG_W = WIDE ? 16 : 8;
  localparam logic [ADDR_W-1:0] IREG_OFS = WIDE ? OFS_INIT_W : OFS_INIT_N;

  logic [IREG_W-1:0] ireg_q;
  logic [DATA_W-1:0] ctrl_q;
  logic              gate_q;
  logic              wr_init;
  logic              field_ok;

  assign wr_init  = we_i && (addr_i == IREG_OFS);
  assign field_ok = (wdata_i[CW-1:0] >= CW'(INIT_FLOOR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ireg_q <= IREG_W'(INIT_FLOOR);
      ctrl_q <= DATA_W'(1) << HALT_BIT;
      gate_q <= 1'b1;
    end else begin
      if (wr_init) begin
        ireg_q[IREG_W-1:CW] <= wdata_i[IREG_W-1:CW];
        if (field_ok) ireg_q[CW-1:0] <= wdata_i[CW-1:0];
      end
      if (we_i && addr_i == OFS_CTRL) ctrl_q <= wdata_i;
      if (we_i && addr_i == OFS_GATE) gate_q <= wdata_i[0];
    end
  end

  assign init_o   = ireg_q[CW-1:0];
  assign halt_o   = ctrl_q[HALT_BIT];
  assign gate_o   = gate_q;
  assign reload_o = we_i && (addr_i == OFS_CNT);
  assign clr_to_o = we_i && (addr_i == OFS_STAT_A) && wdata_i[TO_BIT];
  assign clr_b_o  = (we_i && addr_i == OFS_STAT_B) ? wdata_i[1:0] : 2'b00;

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_CNT)         rdata_o = DATA_W'(cnt_i);
    else if (addr_i == IREG_OFS)   rdata_o = DATA_W'(ireg_q);
    else if (addr_i == OFS_STAT_A) rdata_o[TO_BIT] = to_flag_i;
    else if (addr_i == OFS_STAT_B) rdata_o[1:0] = stat_b_i;
    else if (addr_i == OFS_CTRL)   rdata_o = ctrl_q;
    else if (addr_i == OFS_GATE)   rdata_o[0] = gate_q;
  end

  a_r3_field_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o >= CW'(INIT_FLOOR));
  a_r3_reject_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_init && !field_ok) |=> $stable(init_o));
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer #(
  parameter bit WIDE      = 1'b0,
  parameter int TICK_CLKS = 150_000_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [4:0]  addr_i,
  input  logic        we_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        timeout_o,
  output logic        sys_rst_o
);
  localparam int CW = WIDE ? 10 : 6;

  logic          tick;
  logic          halt;
  logic          gate;
  logic          reload;
  logic          expire;
  logic          clr_to;
  logic [1:0]    clr_b;
  logic [CW-1:0] init_val;
  logic [CW-1:0] cnt;
  logic          to_flag;
  logic [1:0]    stat_b;

  wdg_prescaler #(.TICK_CLKS(TICK_CLKS)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  wdg_counter #(.CW(CW)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .halt_i(halt),
    .reload_i(reload), .init_i(init_val), .cnt_o(cnt), .expire_o(expire)
  );

  wdg_status u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .expire_i(expire), .gate_i(gate),
    .clr_to_i(clr_to), .clr_b_i(clr_b), .to_flag_o(to_flag),
    .stat_b_o(stat_b), .sys_rst_o(sys_rst_o)
  );

  wdg_regs #(.WIDE(WIDE), .CW(CW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .cnt_i(cnt), .to_flag_i(to_flag), .stat_b_i(stat_b),
    .rdata_o(rdata_o), .init_o(init_val), .halt_o(halt), .gate_o(gate),
    .reload_o(reload), .clr_to_o(clr_to), .clr_b_o(clr_b)
  );

  assign timeout_o = to_flag;

  a_r9_gate_blocks_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> !$past(gate));
endmodule

// File: tb/tb_wdg_timer.sv
module tb_wdg_timer;
  localparam int TICK = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rd_n, rd_w;
  logic        to_n, to_w, sr_n, sr_w;

  int tests = 0;
  int fails = 0;
  int pulses = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdg_timer #(.WIDE(1'b0), .TICK_CLKS(TICK)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rd_n), .timeout_o(to_n), .sys_rst_o(sr_n));
  wdg_timer #(.WIDE(1'b1), .TICK_CLKS(TICK)) dut_w (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rd_w), .timeout_o(to_w), .sys_rst_o(sr_w));

  // reference model, index 0 narrow, 1 wide
  int          m_pcnt;
  logic [15:0] m_cnt [2];
  logic [15:0] m_ireg[2];
  logic [15:0] m_ctrl[2];
  logic        m_gate[2];
  logic        m_to  [2];
  logic [1:0]  m_stb [2];
  logic        m_rst [2];

  function automatic logic [15:0] fmask(int v);
    return (v == 1) ? 16'h03FF : 16'h003F;
  endfunction

  function automatic logic [15:0] rmask(int v);
    return (v == 1) ? 16'hFFFF : 16'h00FF;
  endfunction

  function automatic logic [4:0] iofs(int v);
    return (v == 1) ? 5'h12 : 5'h01;
  endfunction

  function automatic logic [15:0] m_read(int v, logic [4:0] a);
    case (a)
      5'h00: return m_cnt[v];
      5'h04: return {12'b0, m_to[v], 3'b0};
      5'h06: return {14'b0, m_stb[v]};
      5'h08: return m_ctrl[v];
      5'h0C: return {15'b0, m_gate[v]};
      default: return (a == iofs(v)) ? m_ireg[v] : 16'h0000;
    endcase
  endfunction

  logic tk, rl, ex, sec;
  logic [15:0] fm, fld;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pcnt <= 0;
      for (int v = 0; v < 2; v++) begin
        m_cnt[v] <= 16'd4; m_ireg[v] <= 16'd4; m_ctrl[v] <= 16'h0800;
        m_gate[v] <= 1'b1; m_to[v] <= 1'b0; m_stb[v] <= 2'b00; m_rst[v] <= 1'b0;
      end
    end else begin
      tk = (m_pcnt == TICK - 1);
      m_pcnt <= tk ? 0 : m_pcnt + 1;
      for (int v = 0; v < 2; v++) begin
        fm  = fmask(v);
        fld = m_ireg[v] & fm;
        rl  = we && addr == 5'h00;
        ex  = tk && !m_ctrl[v][11] && !rl && m_cnt[v] == 0;
        sec = ex && m_to[v];
        if (rl || ex) m_cnt[v] <= fld;
        else if (tk && !m_ctrl[v][11]) m_cnt[v] <= m_cnt[v] - 1;
        if (ex) m_to[v] <= 1'b1;
        else if (we && addr == 5'h04 && wdata[3]) m_to[v] <= 1'b0;
        if (sec) m_stb[v][1] <= 1'b1;
        else if (we && addr == 5'h06 && wdata[1]) m_stb[v][1] <= 1'b0;
        if (sec && !m_gate[v]) m_stb[v][0] <= 1'b1;
        else if (we && addr == 5'h06 && wdata[0]) m_stb[v][0] <= 1'b0;
        m_rst[v] <= sec && !m_gate[v];
        if (we && addr == 5'h08) m_ctrl[v] <= wdata;
        if (we && addr == 5'h0C) m_gate[v] <= wdata[0];
        if (we && addr == iofs(v))
          m_ireg[v] <= (wdata & ~fm & rmask(v)) |
                       (((wdata & fm) >= 16'd4) ? (wdata & fm) : fld);
      end
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // outputs every cycle: R7 timeout level, R8 and R9 reset pulse
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 timeout_o narrow", {15'b0, to_n}, {15'b0, m_to[0]});
      chk("R7 timeout_o wide",   {15'b0, to_w}, {15'b0, m_to[1]});
      chk("R8 sys_rst_o narrow", {15'b0, sr_n}, {15'b0, m_rst[0]});
      chk("R8 sys_rst_o wide",   {15'b0, sr_w}, {15'b0, m_rst[1]});
      if (sr_n) pulses++;
    end
  end

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, string tag);
    @(negedge clk); addr = a; we = 1'b0;
    #1;
    chk({tag, " narrow"}, rd_n, m_read(0, a));
    chk({tag, " wide"},   rd_w, m_read(1, a));
  endtask

  task automatic summary();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    logic [4:0] ofs [7] = '{5'h00, 5'h01, 5'h04, 5'h06, 5'h08, 5'h0C, 5'h12};
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values, explicit constants
    @(negedge clk); addr = 5'h08; #1; chk("R1 ctrl", rd_n, 16'h0800);
    @(negedge clk); addr = 5'h0C; #1; chk("R1 gate", rd_n, 16'h0001);
    @(negedge clk); addr = 5'h00; #1; chk("R1 count", rd_n, 16'h0004);
    @(negedge clk); addr = 5'h01; #1; chk("R1 init narrow", rd_n, 16'h0004);
    chk("R3 unused init ofs wide", rd_w, 16'h0000);
    @(negedge clk); addr = 5'h12; #1; chk("R1 init wide", rd_w, 16'h0004);
    @(negedge clk); addr = 5'h04; #1; chk("R1 stat a", rd_n, 16'h0000);
    @(negedge clk); addr = 5'h06; #1; chk("R1 stat b", rd_w, 16'h0000);

    // R3 rejected field, stored upper bits
    wr(5'h01, 16'h00C2);
    @(negedge clk); addr = 5'h01; #1; chk("R3 reject low narrow", rd_n, 16'h00C4);
    wr(5'h12, 16'hFC03);
    @(negedge clk); addr = 5'h12; #1; chk("R3 reject low wide", rd_w, 16'hFC04);
    wr(5'h01, 16'h003F);
    wr(5'h12, 16'h03FF);
    rd(5'h01, "R3 max narrow"); rd(5'h12, "R3 max wide");

    // R4 reload while halted, R5 hold
    wr(5'h00, 16'hABCD);
    @(negedge clk); addr = 5'h00; #1;
    chk("R4 reload narrow", rd_n, 16'h003F); chk("R2 wide count", rd_w, 16'h03FF);
    repeat (40) @(negedge clk);
    rd(5'h00, "R5 halted hold");

    // R6 running
    wr(5'h01, 16'h0006); wr(5'h12, 16'h0005); wr(5'h00, 16'h0000);
    wr(5'h08, 16'h1234);
    rd(5'h08, "R5 ctrl readback");
    for (int i = 0; i < 6; i++) begin
      repeat (5) @(negedge clk);
      rd(5'h00, "R6 decrement");
    end

    // R7 first expiry, R9 gated second expiry
    repeat (80) @(negedge clk);
    rd(5'h04, "R7 flag");
    repeat (80) @(negedge clk);
    rd(5'h06, "R9 gated status");
    chk("R9 no pulse while gated", 16'(pulses), 16'd0);

    // R8 ungated second expiry
    wr(5'h0C, 16'h0000);
    rd(5'h0C, "R9 gate readback");
    repeat (80) @(negedge clk);
    rd(5'h06, "R8 status");
    chk("R8 pulse seen", 16'(pulses > 0), 16'd1);

    // R10 write-1-to-clear, halted to keep it quiet
    wr(5'h08, 16'h0800);
    wr(5'h04, 16'hFFF7); rd(5'h04, "R10 zero keeps");
    wr(5'h04, 16'h0008); rd(5'h04, "R10 clear a");
    wr(5'h06, 16'h0001); rd(5'h06, "R10 clear b0");
    wr(5'h06, 16'h0003); rd(5'h06, "R10 clear b");

    // R4 reload on a tick edge wins over decrement
    wr(5'h01, 16'h0009); wr(5'h12, 16'h000B); wr(5'h08, 16'h0000);
    repeat (20) @(negedge clk);
    while (m_pcnt != TICK - 1) @(negedge clk);
    addr = 5'h00; we = 1'b1; wdata = 16'h5555;
    @(negedge clk); we = 1'b0; #1;
    chk("R4 reload on tick narrow", rd_n, 16'h0009);
    chk("R4 reload on tick wide",   rd_w, 16'h000B);

    // random traffic
    for (int n = 0; n < 1500; n++) begin
      logic [4:0]  a;
      logic [15:0] d;
      a = ($urandom % 8 == 7) ? 5'($urandom) : ofs[$urandom % 7];
      d = 16'($urandom);
      if (a == 5'h01 || a == 5'h12) d = d & 16'hFC3F;
      if ($urandom % 2 == 0) wr(a, d);
      repeat ($urandom % 20) @(negedge clk);
      rd(ofs[$urandom % 7], "R2 R3 R5 R10 random");
    end

    summary();
  end
endmodule